// File: doc/BRIEF.md
# Serial Configuration Loader

This block brings up a target programmable device over its slow serial configuration pins. A start request pulls the target's configuration-reset line low for a programmable number of clocks and then releases it. The block then waits for the target to report that it is ready. Once it is, the block accepts a given number of image bytes from a valid/ready source. It sends each byte out one bit at a time on a data pin, under a clock that the block generates.

Once the last byte has gone out, the block keeps pulsing the configuration clock until the target reports that it has started. Both waits have an upper bound. Running past either bound, or receiving an error from the byte source, ends the run with a sticky error flag. A successful run sets a sticky loaded flag. Both flags are cleared by the next accepted start.

The two status inputs from the target idle high through pull-ups. Each one passes through a two-flop synchronizer that resets high. The readiness input is only believed once the block has spent two clocks in the ready wait, which lets the synchronizer flush.

Top module: `serial_cfg_seq`

## Requirements
- R1: While reset is held and right after it, cfg_rst_n is 1, cfg_clk is 0, cfg_data is 0, and busy, loaded, error and src_ready are all 0.
- R2: A start seen while idle drives cfg_rst_n low for exactly max(pulse_cycles,1) clocks and then returns it high. cfg_clk does not pulse while cfg_rst_n is low.
- R3: Suppose tgt_ready stays low for INIT_WAIT clocks after cfg_rst_n is released. Then the run ends with error=1 and busy=0, no cfg_clk pulse is produced, and no byte is accepted.
- R4: Each byte goes out most significant bit first. cfg_data is held stable while cfg_clk is high, and the target samples it on the rising edge. Every high phase of cfg_clk lasts exactly max(clk_hi,1) clocks. Every low phase lasts at least max(clk_lo,1) clocks, and the shortest low phase lasts exactly that.
- R5: Exactly byte_count bytes are taken, each on a clock where src_ready and src_valid are both 1, and 8*byte_count data pulses are made. With byte_count = 0 the block goes straight to the trailing pulses.
- R6: If src_err is 1 while src_ready is 1, no further bytes are taken and no further cfg_clk pulses are produced. The run then ends with error=1.
- R7: After the data, trailing cfg_clk pulses continue until tgt_up is seen high. The run then ends with loaded=1 and error=0. Because of the synchronizer, the number of trailing pulses is between the pulse on which tgt_up rose and two pulses after it.
- R8: If tgt_up never rises, exactly DONE_WAIT trailing pulses are produced and the run ends with error=1, loaded=0.
- R9: A start while busy is ignored and does not restart the reset pulse. A start while idle clears loaded and error. loaded and error are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (sampled while idle) |
| pulse_cycles | input | PW | Reset pulse length in clocks (0 acts as 1) |
| clk_hi | input | HW | cfg_clk high phase in clocks (0 acts as 1) |
| clk_lo | input | HW | cfg_clk low phase in clocks (0 acts as 1) |
| byte_count | input | CW | Number of image bytes to send |
| src_data | input | 8 | Image byte from the source |
| src_valid | input | 1 | src_data holds a byte |
| src_err | input | 1 | The source has failed |
| src_ready | output | 1 | The block takes a byte this clock if src_valid is 1 |
| tgt_ready | input | 1 | Target ready-for-data status (pulled high) |
| tgt_up | input | 1 | Target configured status (pulled high) |
| cfg_rst_n | output | 1 | Target configuration reset, active low |
| cfg_clk | output | 1 | Generated configuration clock |
| cfg_data | output | 1 | Serial image data |
| busy | output | 1 | A run is in progress |
| loaded | output | 1 | Sticky: the last run succeeded |
| error | output | 1 | Sticky: the last run failed |

## Verification
The bench receives the serial stream bit by bit and rebuilds the bytes. This catches a design that shifts least significant bit first, or that drops or repeats a bit at a byte boundary where a new byte is fetched. It times every cfg_clk phase, including with zero settings, so an off-by-one phase counter or a missing clamp shows up as wrong high-phase lengths. The timeout cases count pulses exactly, which exposes a trailing counter that stops one pulse early or late, or a ready wait that trusts the stale high value still in the synchronizer. Two more cases target the start and error paths. A restart while busy would show up as a longer reset pulse. A source error ignored at the handshake would show up as extra data pulses.

// File: rtl/serial_cfg_seq.sv
module serial_cfg_seq #(
  parameter int PW = 24,
  parameter int HW = 8,
  parameter int CW = 24,
  parameter int INIT_WAIT = 100000,
  parameter int DONE_WAIT = 100000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] pulse_cycles,
  input  logic [HW-1:0] clk_hi,
  input  logic [HW-1:0] clk_lo,
  input  logic [CW-1:0] byte_count,
  input  logic [7:0]    src_data,
  input  logic          src_valid,
  input  logic          src_err,
  output logic          src_ready,
  input  logic          tgt_ready,
  input  logic          tgt_up,
  output logic          cfg_rst_n,
  output logic          cfg_clk,
  output logic          cfg_data,
  output logic          busy,
  output logic          loaded,
  output logic          error
);
  localparam int IW = $clog2(INIT_WAIT + 1);
  localparam int DW = $clog2(DONE_WAIT + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_WAIT, S_FETCH, S_LO, S_HI, S_TLO, S_THI
  } state_t;

  state_t        state;
  logic [PW-1:0] tmr;
  logic [IW-1:0] icnt;
  logic [DW-1:0] pcnt;
  logic [CW-1:0] bcnt;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic [1:0]    rdy_sync, up_sync;

  wire rdy_s = rdy_sync[1];
  wire up_s  = up_sync[1];
  wire [PW-1:0] hi_ld = (clk_hi == '0) ? '0 : PW'(clk_hi - 1'b1);
  wire [PW-1:0] lo_ld = (clk_lo == '0) ? '0 : PW'(clk_lo - 1'b1);

  assign busy      = (state != S_IDLE);
  assign src_ready = (state == S_FETCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_sync <= 2'b11;
      up_sync  <= 2'b11;
    end else begin
      rdy_sync <= {rdy_sync[0], tgt_ready};
      up_sync  <= {up_sync[0], tgt_up};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cfg_rst_n <= 1'b1;
      cfg_clk   <= 1'b0;
      cfg_data  <= 1'b0;
      loaded    <= 1'b0;
      error     <= 1'b0;
      tmr       <= '0;
      icnt      <= '0;
      pcnt      <= '0;
      bcnt      <= '0;
      bitn      <= '0;
      shreg     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          loaded    <= 1'b0;
          error     <= 1'b0;
          cfg_rst_n <= 1'b0;
          cfg_clk   <= 1'b0;
          cfg_data  <= 1'b0;
          tmr       <= (pulse_cycles == '0) ? '0 : pulse_cycles - 1'b1;
          state     <= S_PULSE;
        end
        S_PULSE: if (tmr == '0) begin
          cfg_rst_n <= 1'b1;
          icnt      <= '0;
          state     <= S_WAIT;
        end else tmr <= tmr - 1'b1;
        S_WAIT: if (rdy_s && icnt >= IW'(2)) begin
          bcnt  <= byte_count;
          tmr   <= lo_ld;
          pcnt  <= '0;
          state <= (byte_count == '0) ? S_TLO : S_FETCH;
        end else if (icnt == IW'(INIT_WAIT - 1)) begin
          error <= 1'b1;
          state <= S_IDLE;
        end else icnt <= icnt + 1'b1;
        S_FETCH: if (src_err) begin
          error <= 1'b1;
          state <= S_IDLE;
        end else if (src_valid) begin
          shreg    <= src_data;
          cfg_data <= src_data[7];
          bitn     <= 3'd7;
          bcnt     <= bcnt - 1'b1;
          tmr      <= lo_ld;
          state    <= S_LO;
        end
        S_LO: if (tmr == '0) begin
          cfg_clk <= 1'b1;
          tmr     <= hi_ld;
          state   <= S_HI;
        end else tmr <= tmr - 1'b1;
        S_HI: if (tmr == '0) begin
          cfg_clk <= 1'b0;
          if (bitn != 3'd0) begin
            bitn     <= bitn - 1'b1;
            cfg_data <= shreg[bitn - 3'd1];
            tmr      <= lo_ld;
            state    <= S_LO;
          end else if (bcnt != '0) begin
            state <= S_FETCH;
          end else begin
            tmr   <= lo_ld;
            pcnt  <= '0;
            state <= S_TLO;
          end
        end else tmr <= tmr - 1'b1;
        S_TLO: if (tmr == '0) begin
          if (up_s) begin
            loaded <= 1'b1;
            state  <= S_IDLE;
          end else if (pcnt == DW'(DONE_WAIT)) begin
            error <= 1'b1;
            state <= S_IDLE;
          end else begin
            cfg_clk <= 1'b1;
            pcnt    <= pcnt + 1'b1;
            tmr     <= hi_ld;
            state   <= S_THI;
          end
        end else tmr <= tmr - 1'b1;
        S_THI: if (tmr == '0) begin
          cfg_clk <= 1'b0;
          tmr     <= lo_ld;
          state   <= S_TLO;
        end else tmr <= tmr - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_data));
  // R2
  no_clk_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rst_n |-> (!cfg_clk && !src_ready));
  // R5
  fetch_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> !cfg_clk);
  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(loaded && error));
  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_rst_n && start) |=> cfg_rst_n);
  // R7
  loaded_clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loaded) |-> (!cfg_clk && !busy));
endmodule

// File: tb/test_serial_cfg_seq.sv
module test_serial_cfg_seq;
  localparam int PW = 24, HW = 8, CW = 24;
  localparam int IWAIT = 30, DWAIT = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PW-1:0] pulse_cycles = '0;
  logic [HW-1:0] clk_hi = 8'd1, clk_lo = 8'd1;
  logic [CW-1:0] byte_count = '0;
  logic [7:0] src_data;
  logic src_valid = 1'b1, src_err;
  logic src_ready, cfg_rst_n, cfg_clk, cfg_data, busy, loaded, error;
  logic tgt_ready = 1'b1, tgt_up = 1'b1;

  int checks = 0, fails = 0, cyc = 0;
  int acc = 0, err_at = -1;
  int rises, prog_lo, hirun, lorun, lomin, hi_bad, bits, data_bad;
  int exp_hi, n_bytes, init_delay, done_after, init_ctr;
  bit init_never, done_never, clk_q;
  logic [7:0] rxbyte;

  serial_cfg_seq #(.PW(PW), .HW(HW), .CW(CW), .INIT_WAIT(IWAIT), .DONE_WAIT(DWAIT))
  i_serial_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pulse_cycles(pulse_cycles),
    .clk_hi(clk_hi), .clk_lo(clk_lo), .byte_count(byte_count),
    .src_data(src_data), .src_valid(src_valid), .src_err(src_err),
    .src_ready(src_ready), .tgt_ready(tgt_ready), .tgt_up(tgt_up),
    .cfg_rst_n(cfg_rst_n), .cfg_clk(cfg_clk), .cfg_data(cfg_data),
    .busy(busy), .loaded(loaded), .error(error));

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 90) ^ (i >> 1));
  endfunction

  assign src_data = pat(acc);
  assign src_err  = (acc == err_at);

  always @(posedge clk)
    if (src_ready && src_valid && !src_err) acc <= acc + 1;

  // target model and stream monitor, at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!cfg_rst_n) begin
      prog_lo++; tgt_ready = 1'b0; tgt_up = 1'b0; init_ctr = 0;
    end else if (!tgt_ready && !init_never) begin
      if (init_ctr >= init_delay) tgt_ready = 1'b1; else init_ctr++;
    end
    if (cfg_clk) begin
      hirun++;
      if (!clk_q) begin
        rises++;
        if (rises > 1 && lorun < lomin) lomin = lorun;
        lorun = 0;
        if (rises <= 8 * n_bytes) begin
          rxbyte = {rxbyte[6:0], cfg_data};
          bits++;
          if (bits % 8 == 0 && rxbyte != pat(bits / 8 - 1)) data_bad++;
        end
        if (!done_never && rises >= 8 * n_bytes + done_after) tgt_up = 1'b1;
      end
    end else begin
      if (clk_q && hirun != exp_hi) hi_bad++;
      hirun = 0;
      lorun++;
    end
    clk_q = cfg_clk;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic launch(int n, int pl, int hi, int lo, int idl, int dn);
    @(negedge clk); #2;
    byte_count = CW'(n); pulse_cycles = PW'(pl);
    clk_hi = HW'(hi); clk_lo = HW'(lo);
    n_bytes = n; init_delay = idl; done_after = dn;
    exp_hi = (hi == 0) ? 1 : hi;
    rises = 0; prog_lo = 0; hirun = 0; lorun = 0; lomin = 1000000;
    hi_bad = 0; bits = 0; data_bad = 0; acc = 0;
    start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && busy; k++) begin
      @(negedge clk); #2;
    end
    #1;
  endtask

  localparam int NV = 4;
  localparam int VEC [NV][6] = '{
    '{3, 4, 1, 1, 3, 1},
    '{5, 0, 2, 3, 0, 4},
    '{0, 2, 1, 1, 5, 2},
    '{2, 1, 0, 0, 1, 6}
  };

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    init_never = 0; done_never = 0; n_bytes = 0; init_delay = 0; done_after = 1;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk(cfg_rst_n == 1'b1, "R1 cfg_rst_n", cfg_rst_n, 1);
    chk(cfg_clk == 1'b0 && cfg_data == 1'b0, "R1 cfg_clk/cfg_data", {cfg_clk, cfg_data}, 0);
    chk(!busy && !loaded && !error && !src_ready, "R1 status", {busy, loaded, error, src_ready}, 0);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && cfg_rst_n && !cfg_clk, "R1 after release", {busy, cfg_rst_n, cfg_clk}, 3'b010);

    for (int v = 0; v < NV; v++) begin
      int n, lo_e, tr;
      n = VEC[v][0];
      lo_e = (VEC[v][3] == 0) ? 1 : VEC[v][3];
      launch(n, VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
      wait_idle();
      tr = rises - 8 * n;
      chk(prog_lo == ((VEC[v][1] == 0) ? 1 : VEC[v][1]), "R2 reset pulse length", prog_lo,
          (VEC[v][1] == 0) ? 1 : VEC[v][1]);
      chk(data_bad == 0 && bits == 8 * n, "R4 serial bytes msb first", bits, 8 * n);
      chk(hi_bad == 0, "R4 high phase length", hi_bad, 0);
      if (rises > 1) chk(lomin == lo_e, "R4 shortest low phase", lomin, lo_e);
      chk(acc == n, "R5 bytes taken", acc, n);
      chk(loaded && !error, "R7 loaded", {loaded, error}, 2'b10);
      chk(tr >= VEC[v][5] && tr <= VEC[v][5] + 2, "R7 trailing pulses", tr, VEC[v][5]);
    end

    // R9 loaded cleared by new start; start while busy ignored
    launch(2, 3, 1, 2, 2, 1);
    chk(!loaded && busy, "R9 loaded cleared on start", {loaded, busy}, 2'b01);
    repeat (2) @(negedge clk);
    #2 start = 1'b1;
    repeat (12) @(negedge clk);
    #2 start = 1'b0;
    wait_idle();
    chk(prog_lo == 3, "R9 start while busy ignored", prog_lo, 3);
    chk(acc == 2 && bits == 16 && data_bad == 0, "R9 run intact", acc, 2);
    chk(loaded && !error, "R9 flags", {loaded, error}, 2'b10);

    // R3 ready never rises
    init_never = 1;
    launch(2, 2, 1, 1, 0, 1);
    wait_idle();
    chk(error && !loaded && !busy, "R3 ready timeout error", {error, loaded, busy}, 3'b100);
    chk(rises == 0 && acc == 0, "R3 no pulses no bytes", rises, 0);
    init_never = 0;

    // R8 tgt_up never rises
    done_never = 1;
    launch(1, 1, 1, 1, 1, 1);
    wait_idle();
    chk(rises - 8 == DWAIT, "R8 trailing pulse count", rises - 8, DWAIT);
    chk(error && !loaded, "R8 timeout error", {error, loaded}, 2'b10);
    done_never = 0;

    // R6 source error after two bytes
    err_at = 2;
    launch(5, 1, 1, 1, 1, 1);
    wait_idle();
    chk(acc == 2, "R6 bytes taken before error", acc, 2);
    chk(rises == 16 && data_bad == 0, "R6 pulses stop", rises, 16);
    chk(error && !loaded && !busy, "R6 error flag", {error, loaded, busy}, 3'b100);
    err_at = -1;

    // R5 recovers and runs again after an error
    launch(1, 1, 2, 1, 0, 1);
    wait_idle();
    chk(acc == 1 && bits == 8 && data_bad == 0 && loaded, "R5 single byte run", acc, 1);

    finish_run();
  end
endmodule